// File: doc/BRIEF.md
# Exception Control Coprocessor

This block is the system-control coprocessor beside a simple 32-bit RISC pipeline. It keeps four control registers: a status word, a cause word, a saved restart address and a captured faulting address. These sit in a 16-entry register space, and the core reaches them through one move-to (write) port and one move-from (read) port, each addressed by a 4-bit register number.

Each cycle the block looks at the core's synchronous trap request and its eight asynchronous interrupt lines. A trap is always accepted. An interrupt is accepted only when the global enable in the status word is set and the line's mask bit is set. On acceptance, in the same cycle, the block drives a redirect to the fixed handler address 0x80000080. At the next clock edge it records the cause code and the restart address, and records the faulting address when the trap is address-related. It pushes the current mode pair (kernel flag, interrupt enable) onto a two-deep stack, so that the handler runs in kernel mode with interrupts off. A return-from-exception strobe pops the stack.

Top module: `sysctl_cop`

## Requirements
- R1: After reset, register 12 reads 0x00000002 (kernel mode, interrupts disabled). Registers 8, 13 and 14 read 0 while no interrupt line is high.
- R2: Any register number other than 8, 12, 13 and 14 reads 0. A move-to write to such a number changes nothing that can be read back.
- R3: A cycle with `trap_valid_i` high raises `redirect_valid_o` in that same cycle, with `redirect_pc_o` = 0x80000080, whatever the status word holds. When nothing is accepted, `redirect_pc_o` is 0.
- R4: An interrupt is accepted only when status bit 0 (global enable) is 1 and, for some line n with `irq_i[n]` high, status bit 8+n (line mask) is also 1.
- R5: If a trap and an enabled interrupt are present in the same cycle, the trap's code is the one recorded.
- R6: On acceptance, cause bits 6:2 are loaded with the code (the trap code for a trap, 0 for an interrupt), and register 14 is loaded with `restart_pc_i`. The code field keeps its value between acceptances.
- R7: Register 8 is loaded with `trap_badaddr_i` only on an accepted trap that has `trap_addr_err_i` high. Otherwise it holds its value.
- R8: On acceptance, status bits 1:0 (kernel flag in bit 1, enable in bit 0) move into bits 3:2, and bits 1:0 become 2'b10.
- R9: A return strobe `eret_i` in a cycle with no acceptance copies status bits 3:2 into bits 1:0 and leaves bits 3:2 unchanged.
- R10: Cause bits 15:8 show the value `irq_i` had at the previous clock edge, whether or not any enable or mask bit is set.
- R11: A move-to write of register 12 stores bits 15:8 and 3:0, and the other bits read 0. A write of register 14 stores all 32 bits. Writes to registers 8 and 13 are ignored. An acceptance in the same cycle overrides the write on the fields it loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, release synchronised inside |
| irq_i | input | 8 | Interrupt request lines |
| trap_valid_i | input | 1 | Synchronous trap request from the running instruction |
| trap_code_i | input | 5 | Code of the trap |
| trap_addr_err_i | input | 1 | Trap is address-related |
| trap_badaddr_i | input | 32 | Faulting address for an address-related trap |
| restart_pc_i | input | 32 | Address at which to resume after the handler |
| eret_i | input | 1 | Return-from-exception strobe |
| mt_en_i | input | 1 | Move-to write strobe |
| mt_sel_i | input | 4 | Register number written |
| mt_data_i | input | 32 | Write data |
| mf_sel_i | input | 4 | Register number read |
| mf_data_o | output | 32 | Read data (combinational) |
| redirect_valid_o | output | 1 | An exception is accepted this cycle |
| redirect_pc_o | output | 32 | Handler address while accepting, else 0 |
| kernel_o | output | 1 | Core is in kernel mode |

## Verification
A corrupted mode stack appears as a wrong status read-back in the cycle after an acceptance or return. When that stack holds a stale enable, an interrupt is wrongly accepted or refused on `redirect_valid_o` in the very cycle the line is raised. A wrong priority choice or a wrong capture enable is not visible at the redirect. It shows one cycle later, when register 13, 14 or 8 is read. For that reason every acceptance in the bench is followed at once by reads of those registers, before any other event can overwrite them.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
  localparam int SELW  = 4;
  localparam int CODEW = 5;

  localparam logic [SELW-1:0] SEL_BADVA  = 4'd8;
  localparam logic [SELW-1:0] SEL_STATUS = 4'd12;
  localparam logic [SELW-1:0] SEL_CAUSE  = 4'd13;
  localparam logic [SELW-1:0] SEL_EPC    = 4'd14;

  localparam int CODE_LSB    = 2;
  localparam int PEND_LSB    = 8;
  localparam int ST_IE       = 0;
  localparam int ST_KM       = 1;
  localparam int ST_PIE      = 2;
  localparam int ST_PKM      = 3;
  localparam int ST_MASK_LSB = 8;

  localparam logic [CODEW-1:0] CODE_INTR = '0;

  typedef struct packed {
    logic km;
    logic ie;
  } mode_t;

  localparam mode_t MODE_HANDLER = '{km: 1'b1, ie: 1'b0};
endpackage

// File: rtl/sysctl_arb.sv
`timescale 1ns/1ps
module sysctl_arb
  import sysctl_pkg::*;
#(
  parameter int NIRQ = 8
) (
  input  logic [NIRQ-1:0]  irq_i,
  input  logic [NIRQ-1:0]  mask_i,
  input  logic             ie_i,
  input  logic             trap_valid_i,
  input  logic [CODEW-1:0] trap_code_i,
  output logic             take_o,
  output logic             trap_sel_o,
  output logic [CODEW-1:0] code_o
);
  logic irq_hit;

  always_comb begin
    irq_hit    = ie_i && ((irq_i & mask_i) != '0);
    trap_sel_o = trap_valid_i;
    take_o     = trap_valid_i || irq_hit;
    code_o     = trap_valid_i ? trap_code_i : CODE_INTR;
  end
endmodule

// File: rtl/sysctl_status.sv
`timescale 1ns/1ps
module sysctl_status
  import sysctl_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 8
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            take_i,
  input  logic            eret_i,
  input  logic            wr_en_i,
  input  logic [3:0]      wr_mode_i,
  input  logic [NIRQ-1:0] wr_mask_i,
  output logic [XLEN-1:0] status_o,
  output logic            ie_o,
  output logic            km_o,
  output logic [NIRQ-1:0] mask_o
);
  mode_t           cur_q, cur_d, prev_q, prev_d;
  logic [NIRQ-1:0] mask_q, mask_d;
  logic            mode_en, mask_en;

  always_comb begin
    mode_en = take_i || eret_i || wr_en_i;
    mask_en = wr_en_i;
    cur_d   = cur_q;
    prev_d  = prev_q;
    mask_d  = wr_mask_i;
    if (take_i) begin
      prev_d = cur_q;
      cur_d  = MODE_HANDLER;
    end else if (eret_i) begin
      cur_d = prev_q;
    end else if (wr_en_i) begin
      cur_d  = '{km: wr_mode_i[ST_KM],  ie: wr_mode_i[ST_IE]};
      prev_d = '{km: wr_mode_i[ST_PKM], ie: wr_mode_i[ST_PIE]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cur_q  <= MODE_HANDLER;
      prev_q <= '0;
    end else if (mode_en) begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_comb begin
    status_o                         = '0;
    status_o[ST_IE]                  = cur_q.ie;
    status_o[ST_KM]                  = cur_q.km;
    status_o[ST_PIE]                 = prev_q.ie;
    status_o[ST_PKM]                 = prev_q.km;
    status_o[ST_MASK_LSB +: NIRQ]    = mask_q;
    ie_o                             = cur_q.ie;
    km_o                             = cur_q.km;
    mask_o                           = mask_q;
  end

  AST_ENTRY_KERNEL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    take_i |=> (cur_q.km && !cur_q.ie)); // R8
  AST_ENTRY_PUSH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    take_i |=> (prev_q == $past(cur_q))); // R8
  AST_ERET_POP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (eret_i && !take_i) |=> (cur_q == $past(prev_q) && $stable(prev_q))); // R9
endmodule

// File: rtl/sysctl_capture.sv
`timescale 1ns/1ps
module sysctl_capture
  import sysctl_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             take_i,
  input  logic             trap_sel_i,
  input  logic             addr_err_i,
  input  logic [CODEW-1:0] code_i,
  input  logic [XLEN-1:0]  restart_pc_i,
  input  logic [XLEN-1:0]  badaddr_i,
  input  logic [NIRQ-1:0]  irq_i,
  input  logic             epc_wr_en_i,
  input  logic [XLEN-1:0]  wr_data_i,
  output logic [XLEN-1:0]  cause_o,
  output logic [XLEN-1:0]  epc_o,
  output logic [XLEN-1:0]  badva_o
);
  logic [CODEW-1:0] code_q;
  logic [NIRQ-1:0]  pend_q;
  logic [XLEN-1:0]  epc_q, epc_d, badva_q;
  logic             code_en, epc_en, badva_en;

  always_comb begin
    code_en  = take_i;
    badva_en = take_i && trap_sel_i && addr_err_i;
    epc_en   = take_i || epc_wr_en_i;
    epc_d    = take_i ? restart_pc_i : wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) pend_q <= '0;
    else          pend_q <= irq_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     code_q <= '0;
    else if (code_en) code_q <= code_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    epc_q <= '0;
    else if (epc_en) epc_q <= epc_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)      badva_q <= '0;
    else if (badva_en) badva_q <= badaddr_i;
  end

  always_comb begin
    cause_o                       = '0;
    cause_o[CODE_LSB +: CODEW]    = code_q;
    cause_o[PEND_LSB +: NIRQ]     = pend_q;
    epc_o                         = epc_q;
    badva_o                       = badva_q;
  end

  AST_EPC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    take_i |=> (epc_o == $past(restart_pc_i))); // R6
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !take_i |=> $stable(code_q)); // R6
  AST_BADVA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(take_i && trap_sel_i && addr_err_i) |=> $stable(badva_o)); // R7
endmodule

// File: rtl/sysctl_cop.sv
`timescale 1ns/1ps
module sysctl_cop
  import sysctl_pkg::*;
#(
  parameter int              XLEN   = 32,
  parameter int              NIRQ   = 8,
  parameter logic [XLEN-1:0] VECTOR = 32'h8000_0080
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [NIRQ-1:0]  irq_i,
  input  logic             trap_valid_i,
  input  logic [CODEW-1:0] trap_code_i,
  input  logic             trap_addr_err_i,
  input  logic [XLEN-1:0]  trap_badaddr_i,
  input  logic [XLEN-1:0]  restart_pc_i,
  input  logic             eret_i,
  input  logic             mt_en_i,
  input  logic [SELW-1:0]  mt_sel_i,
  input  logic [XLEN-1:0]  mt_data_i,
  input  logic [SELW-1:0]  mf_sel_i,
  output logic [XLEN-1:0]  mf_data_o,
  output logic             redirect_valid_o,
  output logic [XLEN-1:0]  redirect_pc_o,
  output logic             kernel_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             take, trap_sel, ie, km;
  logic [CODEW-1:0] code;
  logic [NIRQ-1:0]  mask;
  logic [XLEN-1:0]  status_w, cause_w, epc_w, badva_w;
  logic             st_wr, epc_wr;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  always_comb begin
    st_wr  = mt_en_i && (mt_sel_i == SEL_STATUS);
    epc_wr = mt_en_i && (mt_sel_i == SEL_EPC);
  end

  sysctl_arb #(.NIRQ(NIRQ)) u_arb (
    .irq_i        (irq_i),
    .mask_i       (mask),
    .ie_i         (ie),
    .trap_valid_i (trap_valid_i),
    .trap_code_i  (trap_code_i),
    .take_o       (take),
    .trap_sel_o   (trap_sel),
    .code_o       (code)
  );

  sysctl_status #(.XLEN(XLEN), .NIRQ(NIRQ)) u_status (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .take_i    (take),
    .eret_i    (eret_i),
    .wr_en_i   (st_wr),
    .wr_mode_i (mt_data_i[3:0]),
    .wr_mask_i (mt_data_i[ST_MASK_LSB +: NIRQ]),
    .status_o  (status_w),
    .ie_o      (ie),
    .km_o      (km),
    .mask_o    (mask)
  );

  sysctl_capture #(.XLEN(XLEN), .NIRQ(NIRQ)) u_capture (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n),
    .take_i       (take),
    .trap_sel_i   (trap_sel),
    .addr_err_i   (trap_addr_err_i),
    .code_i       (code),
    .restart_pc_i (restart_pc_i),
    .badaddr_i    (trap_badaddr_i),
    .irq_i        (irq_i),
    .epc_wr_en_i  (epc_wr),
    .wr_data_i    (mt_data_i),
    .cause_o      (cause_w),
    .epc_o        (epc_w),
    .badva_o      (badva_w)
  );

  always_comb begin
    case (mf_sel_i)
      SEL_BADVA:  mf_data_o = badva_w;
      SEL_STATUS: mf_data_o = status_w;
      SEL_CAUSE:  mf_data_o = cause_w;
      SEL_EPC:    mf_data_o = epc_w;
      default:    mf_data_o = '0;
    endcase
    redirect_valid_o = take;
    redirect_pc_o    = take ? VECTOR : '0;
    kernel_o         = km;
  end

  AST_TRAP_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_n)
    trap_valid_i |-> (redirect_valid_o && redirect_pc_o == VECTOR)); // R3
  AST_TRAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    trap_valid_i |=> (cause_w[CODE_LSB +: CODEW] == $past(trap_code_i))); // R5
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (redirect_valid_o && !trap_valid_i) |-> status_w[ST_IE]); // R4
  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mf_sel_i != SEL_BADVA && mf_sel_i != SEL_STATUS &&
     mf_sel_i != SEL_CAUSE && mf_sel_i != SEL_EPC) |-> (mf_data_o == '0)); // R2
endmodule

// File: tb/tb_sysctl_cop.sv
`timescale 1ns/1ps
module tb_sysctl_cop;
  logic        clk = 1'b0;
  logic        rst_n_i;
  logic [7:0]  irq_i;
  logic        trap_valid_i;
  logic [4:0]  trap_code_i;
  logic        trap_addr_err_i;
  logic [31:0] trap_badaddr_i;
  logic [31:0] restart_pc_i;
  logic        eret_i;
  logic        mt_en_i;
  logic [3:0]  mt_sel_i;
  logic [31:0] mt_data_i;
  logic [3:0]  mf_sel_i;
  logic [31:0] mf_data_o;
  logic        redirect_valid_o;
  logic [31:0] redirect_pc_o;
  logic        kernel_o;

  localparam int K_RD = 0, K_RV = 1, K_PC = 2;
  localparam logic [31:0] VEC = 32'h8000_0080;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  int          kind_q[$];
  string       req_q[$];

  logic [31:0] m_exp, m_obs;
  int          m_kind;
  string       m_req;

  always #2.5 clk = ~clk;

  sysctl_cop dut (
    .clk_i(clk), .rst_n_i(rst_n_i), .irq_i(irq_i),
    .trap_valid_i(trap_valid_i), .trap_code_i(trap_code_i),
    .trap_addr_err_i(trap_addr_err_i), .trap_badaddr_i(trap_badaddr_i),
    .restart_pc_i(restart_pc_i), .eret_i(eret_i),
    .mt_en_i(mt_en_i), .mt_sel_i(mt_sel_i), .mt_data_i(mt_data_i),
    .mf_sel_i(mf_sel_i), .mf_data_o(mf_data_o),
    .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
    .kernel_o(kernel_o)
  );

  // Monitor: pops the scoreboard shortly after each falling edge.
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      m_exp  = exp_q.pop_front();
      m_kind = kind_q.pop_front();
      m_req  = req_q.pop_front();
      case (m_kind)
        K_RD:    m_obs = mf_data_o;
        K_RV:    m_obs = {31'd0, redirect_valid_o};
        default: m_obs = redirect_pc_o;
      endcase
      vectors++;
      if (m_obs !== m_exp) begin
        miscompares++;
        $display("FAIL %s: actual %h expected %h", m_req, m_obs, m_exp);
      end
    end
  end

  task automatic push(input int k, input logic [31:0] v, input string r);
    exp_q.push_back(v);
    kind_q.push_back(k);
    req_q.push_back(r);
  endtask

  task automatic cyc();
    @(negedge clk);
    trap_valid_i    = 1'b0;
    trap_addr_err_i = 1'b0;
    eret_i          = 1'b0;
    mt_en_i         = 1'b0;
  endtask

  task automatic rd_now(input logic [3:0] sel, input logic [31:0] v, input string r);
    mf_sel_i = sel;
    #0.2;
    push(K_RD, v, r);
  endtask

  task automatic rd(input logic [3:0] sel, input logic [31:0] v, input string r);
    cyc();
    rd_now(sel, v, r);
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    cyc();
    mt_en_i   = 1'b1;
    mt_sel_i  = sel;
    mt_data_i = d;
  endtask

  task automatic redir(input bit taken, input string r);
    #0.2;
    push(K_RV, {31'd0, taken}, r);
    push(K_PC, taken ? VEC : 32'd0, r);
  endtask

  initial begin
    rst_n_i = 1'b0; irq_i = '0; trap_valid_i = 1'b0; trap_code_i = '0;
    trap_addr_err_i = 1'b0; trap_badaddr_i = '0; restart_pc_i = '0;
    eret_i = 1'b0; mt_en_i = 1'b0; mt_sel_i = '0; mt_data_i = '0; mf_sel_i = '0;
    repeat (3) @(negedge clk);
    rst_n_i = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    rd(4'd12, 32'h0000_0002, "R1 status");
    rd(4'd13, 32'h0, "R1 cause");
    rd(4'd14, 32'h0, "R1 epc");
    rd(4'd8,  32'h0, "R1 badva");

    // R2 unimplemented number; R11 ignored writes
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, 32'h0, "R2 unimplemented");
    wr(4'd13, 32'hFFFF_FFFF);
    rd(4'd13, 32'h0, "R11 cause ignores write");
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, 32'h0, "R11 badva ignores write");
    wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd12, 32'h0000_FF0F, "R11 status writable fields");

    // user mode, enable on, only line 0 unmasked
    wr(4'd12, 32'h0000_0101);
    rd(4'd12, 32'h0000_0101, "R11 status write");

    // R4 masked line not taken
    cyc(); irq_i = 8'h02; redir(1'b0, "R4 masked line");
    rd(4'd13, 32'h0000_0200, "R10 pending shows masked line");

    // R4 unmasked line taken, R3 vector
    cyc(); irq_i = 8'h03; restart_pc_i = 32'h0000_1000; redir(1'b1, "R4 enabled line");
    cyc(); irq_i = 8'h00; rd_now(4'd13, 32'h0000_0300, "R6 interrupt code 0");
    rd(4'd12, 32'h0000_0106, "R8 mode push");
    rd(4'd14, 32'h0000_1000, "R6 restart address");
    rd(4'd8,  32'h0, "R7 no address capture on interrupt");

    // R9 return
    cyc(); eret_i = 1'b1;
    rd(4'd12, 32'h0000_0105, "R9 mode pop");

    // R5 trap beats enabled interrupt, with address error
    cyc(); irq_i = 8'h01; trap_valid_i = 1'b1; trap_code_i = 5'd5;
    trap_addr_err_i = 1'b1; trap_badaddr_i = 32'hDEAD_BEE0; restart_pc_i = 32'h0000_2004;
    redir(1'b1, "R3 trap redirect");
    cyc(); irq_i = 8'h00; rd_now(4'd13, 32'h0000_0114, "R5 trap code wins");
    rd(4'd8,  32'hDEAD_BEE0, "R7 faulting address");
    rd(4'd14, 32'h0000_2004, "R6 trap restart address");
    rd(4'd12, 32'h0000_0106, "R8 entry from user");

    // R3 trap taken with enable off; R7 hold without address error
    cyc(); trap_valid_i = 1'b1; trap_code_i = 5'd12; trap_badaddr_i = 32'h0000_1111;
    restart_pc_i = 32'h0000_2008;
    redir(1'b1, "R3 trap with enable off");
    rd(4'd8,  32'hDEAD_BEE0, "R7 hold");
    rd(4'd12, 32'h0000_010A, "R8 nested push");
    rd(4'd13, 32'h0000_0030, "R6 cause code");

    // R11 acceptance overrides a same-cycle EPC write
    wr(4'd14, 32'h0000_5555);
    trap_valid_i = 1'b1; trap_code_i = 5'd3; restart_pc_i = 32'h0000_3000;
    rd(4'd14, 32'h0000_3000, "R11 acceptance over write");
    wr(4'd14, 32'h0000_4444);
    rd(4'd14, 32'h0000_4444, "R11 epc write");

    // R4 enable off blocks an unmasked line
    wr(4'd12, 32'h0000_0100);
    rd(4'd12, 32'h0000_0100, "R11 status clear");
    cyc(); irq_i = 8'h01; redir(1'b0, "R4 enable off");
    cyc(); irq_i = 8'h00;

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule